// File: doc/BRIEF.md
# Raster Dot Timing Generator

This block keeps the beam position of a tile-based video processor. Each accepted strobe from the CPU clock domain is worth two dots. The block keeps these dots in a small backlog and spends one dot per clock. A horizontal counter and a vertical counter step through one frame of 340 dots by 262 lines. From that position the block decodes the horizontal and vertical blanking windows. It raises a pixel strobe on each dot that falls in the visible area and gives the byte offset of that pixel in a linear framebuffer with four bytes per pixel.

The visible area does not start at the counter origin. Columns 22 to 277 and lines 1 to 224 are visible. The block also reports the output resolution that the rest of the pipe should assume. The width comes from the background mode field and the height comes from the interlace enable.

The step input is a valid/ready pair. A strobe counts only in a cycle where `cpu_step` and `step_ready` are both high. A strobe in a cycle where `step_ready` is low is dropped and is not held, so the source must present it again. `step_ready` falls once the backlog can no longer take two more dots.

Top module: `raster_dot_timer`

## Requirements
- R1: After reset, h_count and v_count are 0, pix_valid is low, pix_index is 0 and step_ready is high.
- R2: Each accepted strobe adds two dots to a backlog. The backlog starts empty after reset. On every clock edge where the backlog is not empty, one dot is spent and h_count advances by one. Otherwise both counters hold.
- R3: step_ready is high exactly while the backlog holds 13 dots or fewer. A strobe in a cycle where step_ready is low adds no dots.
- R4: When a dot is spent at h_count 339, h_count returns to 0 and v_count advances.
- R5: When a dot is spent at h_count 339 and v_count 261, v_count returns to 0.
- R6: hblank is low exactly while h_count is within 22..277 inclusive.
- R7: vblank is low exactly while v_count is within 1..224 inclusive.
- R8: pix_valid is high exactly in the cycles where a dot is spent while both hblank and vblank are low.
- R9: pix_index equals ((h_count-22) + (v_count-1)*512)*4 while both blanking flags are low, and 0 otherwise. The row width of 512 is a parameter.
- R10: res_width is 512 when the 3-bit bg_mode equals 5 or 6, and 256 for the other six codes.
- R11: res_height is 448 when interlace_en is 1, and 224 when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_step | input | 1 | Valid for one CPU-cycle strobe worth two dots |
| step_ready | output | 1 | Backlog can accept one more strobe |
| bg_mode | input | 3 | Background mode field |
| interlace_en | input | 1 | Interlace enable |
| h_count | output | 9 | Horizontal dot position |
| v_count | output | 9 | Vertical line position |
| hblank | output | 1 | Horizontal blanking active |
| vblank | output | 1 | Vertical blanking active |
| pix_valid | output | 1 | Visible dot spent this cycle |
| pix_index | output | 19 | Framebuffer byte offset of the current dot |
| res_width | output | 10 | Output width in pixels |
| res_height | output | 9 | Output height in lines |

## Verification
The bench drives the step input in four patterns. A single isolated strobe shows that one strobe is worth exactly two dots. A strobe on every other clock keeps the backlog at its minimum and separates spending one dot per clock from spending two. A strobe on every clock saturates the backlog, so step_ready toggles and dropped strobes must leave the count unchanged. A long run with strobes on every clock crosses every visible and blanking boundary and both counter wraps, where an off-by-one in a window edge or in the index origin shows up. All eight mode codes are swept against both interlace settings to separate the two wide modes from their neighbours.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned NARROW_W = 256;
  localparam int unsigned WIDE_W   = 512;
  localparam int unsigned PROG_H   = 224;
  localparam int unsigned INTL_H   = 448;
  localparam int unsigned RES_W_BITS = $clog2(WIDE_W + 1);
  localparam int unsigned RES_H_BITS = $clog2(INTL_H + 1);

  function automatic logic in_span(input int unsigned val, input int unsigned lo,
                                   input int unsigned hi);
    return (val >= lo) && (val <= hi);
  endfunction
endpackage

// File: rtl/dot_backlog.sv
module dot_backlog #(
  parameter int unsigned BW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_valid,
  output logic step_ready,
  output logic dot_adv,
  output logic [BW-1:0] level
);
  localparam int unsigned FULL = (1 << BW) - 1;
  localparam logic [BW-1:0] READY_LIMIT = BW'(FULL - 2);

  logic [BW-1:0] lvl_q, lvl_d;
  logic          take;

  assign step_ready = (lvl_q <= READY_LIMIT);
  assign take       = step_valid & step_ready;
  assign dot_adv    = (lvl_q != '0);
  assign level      = lvl_q;

  always_comb begin
    lvl_d = lvl_q;
    if (take)    lvl_d = lvl_d + BW'(2);
    if (dot_adv) lvl_d = lvl_d - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int unsigned H_TOTAL = 340,
  parameter int unsigned V_TOTAL = 262,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_adv,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (dot_adv) begin
      if (h_pos == H_LAST) begin
        h_pos <= '0;
        v_pos <= (v_pos == V_LAST) ? '0 : v_pos + VW'(1);
      end else begin
        h_pos <= h_pos + HW'(1);
      end
    end
  end
endmodule

// File: rtl/raster_window.sv
module raster_window
  import raster_pkg::*;
#(
  parameter int unsigned HW = 9,
  parameter int unsigned VW = 9,
  parameter int unsigned IDX_W = 19,
  parameter int unsigned H_VIS_START = 22,
  parameter int unsigned H_VIS_END = 277,
  parameter int unsigned V_VIS_START = 1,
  parameter int unsigned V_VIS_END = 224,
  parameter int unsigned ROW_W = 512
) (
  input  logic [HW-1:0]    h_pos,
  input  logic [VW-1:0]    v_pos,
  input  logic             dot_adv,
  output logic             hblank,
  output logic             vblank,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_index
);
  localparam logic [IDX_W-1:0] ROW_C = IDX_W'(ROW_W);

  logic             visible;
  logic [IDX_W-1:0] col, row;

  assign hblank    = !in_span(32'(h_pos), H_VIS_START, H_VIS_END);
  assign vblank    = !in_span(32'(v_pos), V_VIS_START, V_VIS_END);
  assign visible   = !hblank && !vblank;
  assign pix_valid = dot_adv && visible;

  assign col = IDX_W'(h_pos - HW'(H_VIS_START));
  assign row = IDX_W'(v_pos - VW'(V_VIS_START));

  always_comb begin
    if (visible) pix_index = (col + row * ROW_C) << 2;
    else         pix_index = '0;
  end
endmodule

// File: rtl/res_decode.sv
module res_decode
  import raster_pkg::*;
#(
  parameter int unsigned MODE_W = 3,
  parameter int unsigned WIDE_MODE_A = 5,
  parameter int unsigned WIDE_MODE_B = 6
) (
  input  logic [MODE_W-1:0]     bg_mode,
  input  logic                  interlace_en,
  output logic [RES_W_BITS-1:0] res_width,
  output logic [RES_H_BITS-1:0] res_height
);
  logic wide;

  assign wide = (bg_mode == MODE_W'(WIDE_MODE_A)) || (bg_mode == MODE_W'(WIDE_MODE_B));
  assign res_width  = wide ? RES_W_BITS'(WIDE_W) : RES_W_BITS'(NARROW_W);
  assign res_height = interlace_en ? RES_H_BITS'(INTL_H) : RES_H_BITS'(PROG_H);
endmodule

// File: rtl/raster_dot_timer.sv
module raster_dot_timer
  import raster_pkg::*;
#(
  parameter int unsigned H_TOTAL = 340,
  parameter int unsigned V_TOTAL = 262,
  parameter int unsigned H_VIS_START = 22,
  parameter int unsigned H_VIS_END = 277,
  parameter int unsigned V_VIS_START = 1,
  parameter int unsigned V_VIS_END = 224,
  parameter int unsigned ROW_W = 512,
  parameter int unsigned BACKLOG_W = 4,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL),
  localparam int unsigned MAX_IDX =
    ((H_VIS_END - H_VIS_START) + (V_VIS_END - V_VIS_START) * ROW_W) * 4,
  localparam int unsigned IDX_W = $clog2(MAX_IDX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_step,
  output logic                  step_ready,
  input  logic [2:0]            bg_mode,
  input  logic                  interlace_en,
  output logic [HW-1:0]         h_count,
  output logic [VW-1:0]         v_count,
  output logic                  hblank,
  output logic                  vblank,
  output logic                  pix_valid,
  output logic [IDX_W-1:0]      pix_index,
  output logic [RES_W_BITS-1:0] res_width,
  output logic [RES_H_BITS-1:0] res_height
);
  logic                 dot_adv;
  logic [BACKLOG_W-1:0] backlog;

  dot_backlog #(.BW(BACKLOG_W)) u_backlog (
    .clk(clk), .rst_n(rst_n), .step_valid(cpu_step), .step_ready(step_ready),
    .dot_adv(dot_adv), .level(backlog)
  );

  raster_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_counter (
    .clk(clk), .rst_n(rst_n), .dot_adv(dot_adv), .h_pos(h_count), .v_pos(v_count)
  );

  raster_window #(
    .HW(HW), .VW(VW), .IDX_W(IDX_W),
    .H_VIS_START(H_VIS_START), .H_VIS_END(H_VIS_END),
    .V_VIS_START(V_VIS_START), .V_VIS_END(V_VIS_END), .ROW_W(ROW_W)
  ) u_window (
    .h_pos(h_count), .v_pos(v_count), .dot_adv(dot_adv), .hblank(hblank),
    .vblank(vblank), .pix_valid(pix_valid), .pix_index(pix_index)
  );

  res_decode #(.MODE_W(3)) u_res (
    .bg_mode(bg_mode), .interlace_en(interlace_en),
    .res_width(res_width), .res_height(res_height)
  );
endmodule

// File: rtl/raster_dot_timer_chk.sv
module raster_dot_timer_chk #(
  parameter int unsigned HW = 9,
  parameter int unsigned VW = 9,
  parameter int unsigned IDX_W = 19,
  parameter int unsigned BW = 4,
  parameter int unsigned H_TOTAL = 340,
  parameter int unsigned V_TOTAL = 262
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_step,
  input logic             step_ready,
  input logic             dot_adv,
  input logic [BW-1:0]    backlog,
  input logic [HW-1:0]    h_count,
  input logic [VW-1:0]    v_count,
  input logic             hblank,
  input logic             vblank,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_index
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_adv && h_count != H_LAST) |=> h_count == $past(h_count) + HW'(1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_adv |=> ($stable(h_count) && $stable(v_count)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_step && !step_ready) |=> backlog == $past(backlog) - BW'(1));
  p_hwrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_adv && h_count == H_LAST) |=> h_count == '0);
  p_vwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_adv && h_count == H_LAST && v_count == V_LAST) |=> v_count == '0);
  p_pix_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (!hblank && !vblank && dot_adv));
  p_idx_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank || vblank) |-> pix_index == '0);
endmodule

bind raster_dot_timer raster_dot_timer_chk #(
  .HW(HW), .VW(VW), .IDX_W(IDX_W), .BW(BACKLOG_W), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_step(cpu_step), .step_ready(step_ready),
  .dot_adv(dot_adv), .backlog(backlog), .h_count(h_count), .v_count(v_count),
  .hblank(hblank), .vblank(vblank), .pix_valid(pix_valid), .pix_index(pix_index)
);

// File: tb/test_raster_dot_timer.sv
`timescale 1ns/1ps
module test_raster_dot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_step = 1'b0;
  logic [2:0]  bg_mode = 3'd0;
  logic        interlace_en = 1'b0;
  logic        step_ready, hblank, vblank, pix_valid;
  logic [8:0]  h_count, v_count;
  logic [18:0] pix_index;
  logic [9:0]  res_width;
  logic [8:0]  res_height;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_bl = 0;
  int m_h = 0;
  int m_v = 0;

  always #5 clk = ~clk;

  raster_dot_timer i_raster_dot_timer (
    .clk(clk), .rst_n(rst_n), .cpu_step(cpu_step), .step_ready(step_ready),
    .bg_mode(bg_mode), .interlace_en(interlace_en), .h_count(h_count),
    .v_count(v_count), .hblank(hblank), .vblank(vblank), .pix_valid(pix_valid),
    .pix_index(pix_index), .res_width(res_width), .res_height(res_height)
  );

  // Reference model: backlog of dots, one spent per clock, and a raster walk.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bl = 0; m_h = 0; m_v = 0;
    end else begin
      bit acc, dot;
      acc = cpu_step && (m_bl <= 13);
      dot = (m_bl != 0);
      if (dot) begin
        if (m_h == 339) begin
          m_h = 0;
          m_v = (m_v == 261) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
      m_bl = m_bl + (acc ? 2 : 0) - (dot ? 1 : 0);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit vis;
    longint idx;
    vis = (m_h >= 22 && m_h <= 277) && (m_v >= 1 && m_v <= 224);
    idx = vis ? ((m_h - 22) + (m_v - 1) * 512) * 4 : 0;
    chk("R2 R4 h_count", h_count, m_h);
    chk("R5 v_count", v_count, m_v);
    chk("R3 step_ready", step_ready, (m_bl <= 13));
    chk("R6 hblank", hblank, !(m_h >= 22 && m_h <= 277));
    chk("R7 vblank", vblank, !(m_v >= 1 && m_v <= 224));
    chk("R8 pix_valid", pix_valid, (m_bl != 0) && vis);
    chk("R9 pix_index", pix_index, idx);
    chk("R10 res_width", res_width, (bg_mode == 3'd5 || bg_mode == 3'd6) ? 512 : 256);
    chk("R11 res_height", res_height, interlace_en ? 448 : 224);
  endtask

  task automatic cyc(input bit s);
    @(negedge clk);
    compare_all();
    cpu_step = s;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 h_count", h_count, 0);
    chk("R1 v_count", v_count, 0);
    chk("R1 pix_valid", pix_valid, 0);
    chk("R1 pix_index", pix_index, 0);
    chk("R1 step_ready", step_ready, 1);

    // R10 R11: all mode codes against both interlace settings
    for (int il = 0; il < 2; il++) begin
      for (int md = 0; md < 8; md++) begin
        @(negedge clk);
        bg_mode = 3'(md);
        interlace_en = il[0];
        cyc(1'b0);
      end
    end
    bg_mode = 3'd1; interlace_en = 1'b0;

    // R2: one isolated strobe, then idle
    cyc(1'b1);
    repeat (6) cyc(1'b0);
    chk("R2 two dots per strobe", h_count, 2);

    // R2: strobe every other clock
    for (int i = 0; i < 400; i++) begin
      cyc(1'b1);
      cyc(1'b0);
    end

    // R3: saturating burst, strobes dropped while not ready
    repeat (40) cyc(1'b1);
    repeat (20) cyc(1'b0);

    // R4 R5 R6 R7 R8 R9: full frame with continuous strobes
    bg_mode = 3'd5; interlace_en = 1'b1;
    repeat (90000) cyc(1'b1);
    repeat (20) cyc(1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule